// File: doc/BRIEF.md
# Event Record Stream Parser

This block takes a byte-serial stream of recorded output events and turns each record back into one wide, parallel event. Bytes arrive on an 8-bit valid/ready channel. A record opens with a byte that gives its total size. A fixed header follows, carrying a channel number, a timestamp and a sub-address. After the header come zero or more 32-bit data words. When the block has gathered the whole record, it presents the fields together on a valid/ready event bus. The bus shows the channel and sub-address both separately and joined into one 32-bit target.

The block checks the size byte of every record. A size it cannot accept raises a one-cycle error pulse, and the parser then consumes and discards the rest of that record. A size byte of zero ends the stream: it raises a one-cycle end pulse and produces no event. While a finished event waits for its consumer, the block stops taking bytes. Output backpressure therefore never drops input.

Top module: `evt_record_parser`

## Requirements
- R1: The first byte of a record gives the total record length in bytes, header included. The header is 13 bytes: the length, 3 channel bytes, 8 timestamp bytes and 1 address byte, in that order. Exactly one event is presented after the last byte of an accepted record.
- R2: Channel and timestamp bytes arrive least-significant byte first. The k-th byte received lands in bits 8k+7:8k of its field.
- R3: The address byte appears on `outAddress`. `outTarget` carries the channel in bits 31:8 and the address in bits 7:0.
- R4: Data words follow the header, (length−13)/4 of them, each sent least-significant byte first. Word j lands in bits 32j+31:32j of `outData`, and every bit above the received words reads zero, whatever an earlier record held.
- R5: A length byte of 1 to 12, above 77, or with (length−13) not a multiple of 4 raises `errPulse` for one cycle, starting in the cycle after the byte is taken. No event is produced for that record.
- R6: After a rejected length byte, the next length−1 bytes are consumed and ignored, including zero bytes. No event and no end pulse arise from them, and the byte after them is parsed as a new length byte.
- R7: A length byte of 0 raises `eosPulse` for one cycle, starting in the cycle after the byte is taken. It produces no event and leaves the parser waiting for a length byte.
- R8: While `outValid` is high and `outReady` is low, `inReady` stays low and all event outputs hold steady. A byte offered during that time is taken once the event has been consumed.
- R9: Synchronous reset makes `inReady` high, sets `outValid`, `errPulse` and `eosPulse` low and clears all assembled fields. It abandons a partly received record, and the next byte is treated as a length byte.
- R10: A record of the maximum length, 77 bytes (16 data words), fills all 512 data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inData | input | 8 | Stream byte |
| inValid | input | 1 | Stream byte present |
| inReady | output | 1 | Parser can take a byte |
| outValid | output | 1 | Assembled event present |
| outReady | input | 1 | Consumer takes the event |
| outChannel | output | 24 | Event channel number |
| outTimestamp | output | 64 | Event timestamp |
| outAddress | output | 8 | Event sub-address |
| outTarget | output | 32 | Channel and sub-address combined |
| outData | output | 512 | Event data, zero-extended |
| errPulse | output | 1 | Malformed length seen |
| eosPulse | output | 1 | End-of-stream marker seen |

## Verification
The bench builds the parser with its default parameters: 24-bit channel, 64-bit timestamp, 8-bit address, 32-bit words and 16 words per record. With these values the largest legal record is 77 bytes and fits in a single length byte. The bench can therefore reach the full-width boundary, the first length above it (81), and a short record sent directly after a full one, which shows the zero-extension. Skipped records filled with zero bytes show that stale data is never mistaken for an end marker.

// File: rtl/evt_record_pkg.sv
package evt_record_pkg;
  localparam int IDX_W = 8;

  typedef enum logic [2:0] {
    S_LEN, S_CHAN, S_TS, S_ADDR, S_DATA, S_SKIP, S_OUT
  } parseState_e;

  typedef struct packed {
    logic             clr;
    logic             ldChan;
    logic             ldTs;
    logic             ldAddr;
    logic             ldData;
    logic [IDX_W-1:0] idx;
  } dpStrobe_t;
endpackage

// File: rtl/evt_record_ctrl.sv
module evt_record_ctrl
  import evt_record_pkg::*;
#(
  parameter int CHAN_B    = 3,
  parameter int TS_B      = 8,
  parameter int ADDR_B    = 1,
  parameter int WORD_B    = 4,
  parameter int MAX_WORDS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] inData,
  input  logic       inValid,
  output logic       inReady,
  output logic       outValid,
  input  logic       outReady,
  output logic       errPulse,
  output logic       eosPulse,
  output dpStrobe_t  strb
);
  localparam int HDR_B   = 1 + CHAN_B + TS_B + ADDR_B;
  localparam int MAX_LEN = HDR_B + WORD_B * MAX_WORDS;

  parseState_e      state, stateN;
  logic [IDX_W-1:0] cnt, cntN, lastIdx, lastN;
  logic             hasData, hasN, errN, eosN;
  logic             accept, lenBad;
  logic [7:0]       dBytes;

  assign inReady  = (state != S_OUT);
  assign outValid = (state == S_OUT);
  assign accept   = inValid && inReady;
  assign dBytes   = inData - 8'(HDR_B);
  assign lenBad   = (inData < 8'(HDR_B)) || (inData > 8'(MAX_LEN)) ||
                    ((dBytes % 8'(WORD_B)) != 8'd0);

  always_comb begin
    stateN   = state;
    cntN     = cnt;
    lastN    = lastIdx;
    hasN     = hasData;
    errN     = 1'b0;
    eosN     = 1'b0;
    strb     = '0;
    strb.idx = cnt;
    case (state)
      S_LEN: if (accept) begin
        if (inData == 8'd0) begin
          eosN = 1'b1;
        end else if (lenBad) begin
          errN = 1'b1;
          if (inData > 8'd1) begin
            stateN = S_SKIP;
            cntN   = '0;
            lastN  = inData - 8'd2;
          end
        end else begin
          strb.clr = 1'b1;
          stateN   = S_CHAN;
          cntN     = '0;
          hasN     = (inData != 8'(HDR_B));
          lastN    = dBytes - 8'd1;
        end
      end
      S_CHAN: if (accept) begin
        strb.ldChan = 1'b1;
        if (cnt == IDX_W'(CHAN_B - 1)) begin
          stateN = S_TS;
          cntN   = '0;
        end else cntN = cnt + 1'b1;
      end
      S_TS: if (accept) begin
        strb.ldTs = 1'b1;
        if (cnt == IDX_W'(TS_B - 1)) begin
          stateN = S_ADDR;
          cntN   = '0;
        end else cntN = cnt + 1'b1;
      end
      S_ADDR: if (accept) begin
        strb.ldAddr = 1'b1;
        if (cnt == IDX_W'(ADDR_B - 1)) begin
          stateN = hasData ? S_DATA : S_OUT;
          cntN   = '0;
        end else cntN = cnt + 1'b1;
      end
      S_DATA: if (accept) begin
        strb.ldData = 1'b1;
        if (cnt == lastIdx) stateN = S_OUT;
        else cntN = cnt + 1'b1;
      end
      S_SKIP: if (accept) begin
        if (cnt == lastIdx) stateN = S_LEN;
        else cntN = cnt + 1'b1;
      end
      S_OUT: if (outReady) stateN = S_LEN;
      default: stateN = S_LEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_LEN;
      cnt      <= '0;
      lastIdx  <= '0;
      hasData  <= 1'b0;
      errPulse <= 1'b0;
      eosPulse <= 1'b0;
    end else begin
      state    <= stateN;
      cnt      <= cntN;
      lastIdx  <= lastN;
      hasData  <= hasN;
      errPulse <= errN;
      eosPulse <= eosN;
    end
  end
endmodule

// File: rtl/evt_record_dpath.sv
module evt_record_dpath
  import evt_record_pkg::*;
#(
  parameter int CHAN_W = 24,
  parameter int TS_W   = 64,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        inData,
  input  dpStrobe_t         strb,
  output logic [CHAN_W-1:0] chanQ,
  output logic [TS_W-1:0]   tsQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic [DATA_W-1:0] dataQ
);
  localparam int CHAN_B = CHAN_W / 8;
  localparam int TS_B   = TS_W / 8;
  localparam int ADDR_B = ADDR_W / 8;
  localparam int DATA_B = DATA_W / 8;

  for (genvar i = 0; i < CHAN_B; i++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst || strb.clr) chanQ[8*i +: 8] <= '0;
      else if (strb.ldChan && strb.idx == IDX_W'(i)) chanQ[8*i +: 8] <= inData;
    end
  end

  for (genvar i = 0; i < TS_B; i++) begin : g_ts
    always_ff @(posedge clk) begin
      if (rst || strb.clr) tsQ[8*i +: 8] <= '0;
      else if (strb.ldTs && strb.idx == IDX_W'(i)) tsQ[8*i +: 8] <= inData;
    end
  end

  for (genvar i = 0; i < ADDR_B; i++) begin : g_addr
    always_ff @(posedge clk) begin
      if (rst || strb.clr) addrQ[8*i +: 8] <= '0;
      else if (strb.ldAddr && strb.idx == IDX_W'(i)) addrQ[8*i +: 8] <= inData;
    end
  end

  for (genvar i = 0; i < DATA_B; i++) begin : g_data
    always_ff @(posedge clk) begin
      if (rst || strb.clr) dataQ[8*i +: 8] <= '0;
      else if (strb.ldData && strb.idx == IDX_W'(i)) dataQ[8*i +: 8] <= inData;
    end
  end
endmodule

// File: rtl/evt_record_parser.sv
module evt_record_parser
  import evt_record_pkg::*;
#(
  parameter int CHAN_W    = 24,
  parameter int TS_W      = 64,
  parameter int ADDR_W    = 8,
  parameter int WORD_W    = 32,
  parameter int MAX_WORDS = 16,
  localparam int DATA_W   = WORD_W * MAX_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        inData,
  input  logic              inValid,
  output logic              inReady,
  output logic              outValid,
  input  logic              outReady,
  output logic [CHAN_W-1:0] outChannel,
  output logic [TS_W-1:0]   outTimestamp,
  output logic [ADDR_W-1:0] outAddress,
  output logic [CHAN_W+ADDR_W-1:0] outTarget,
  output logic [DATA_W-1:0] outData,
  output logic              errPulse,
  output logic              eosPulse
);
  dpStrobe_t strb;

  evt_record_ctrl #(
    .CHAN_B(CHAN_W / 8), .TS_B(TS_W / 8), .ADDR_B(ADDR_W / 8),
    .WORD_B(WORD_W / 8), .MAX_WORDS(MAX_WORDS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .inData(inData), .inValid(inValid),
    .inReady(inReady), .outValid(outValid), .outReady(outReady),
    .errPulse(errPulse), .eosPulse(eosPulse), .strb(strb)
  );

  evt_record_dpath #(
    .CHAN_W(CHAN_W), .TS_W(TS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dpath (
    .clk(clk), .rst(rst), .inData(inData), .strb(strb),
    .chanQ(outChannel), .tsQ(outTimestamp), .addrQ(outAddress), .dataQ(outData)
  );

  assign outTarget = {outChannel, outAddress};
endmodule

// File: rtl/evt_record_parser_chk.sv
module evt_record_parser_chk #(
  parameter int TGT_W  = 32,
  parameter int DATA_W = 512
) (
  input logic              clk,
  input logic              rst,
  input logic [7:0]        inData,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [TGT_W-1:0]  outTarget,
  input logic [DATA_W-1:0] outData,
  input logic              errPulse,
  input logic              eosPulse
);
  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outTarget)); // R8
  AST_NO_INTAKE_DURING_OUT: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !inReady); // R8
  AST_ERR_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
    errPulse |-> !outValid && !eosPulse); // R5
  AST_EOS_AFTER_ZERO: assert property (@(posedge clk) disable iff (rst)
    eosPulse |-> $past(inValid && inReady && inData == 8'd0)); // R7
  AST_EVT_AFTER_INTAKE: assert property (@(posedge clk) disable iff (rst)
    $rose(outValid) |-> $past(inValid && inReady)); // R1
  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> !outValid && !errPulse && !eosPulse && outData == '0); // R9
endmodule

bind evt_record_parser evt_record_parser_chk #(
  .TGT_W(CHAN_W + ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .inData(inData), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outTarget(outTarget),
  .outData(outData), .errPulse(errPulse), .eosPulse(eosPulse)
);

// File: tb/evt_record_parser_bench.sv
`timescale 1ns/1ps
module evt_record_parser_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [7:0]   inData = '0;
  logic         inValid = 1'b0;
  logic         inReady, outValid, errPulse, eosPulse;
  logic         outReady = 1'b0;
  logic [23:0]  outChannel;
  logic [63:0]  outTimestamp;
  logic [7:0]   outAddress;
  logic [31:0]  outTarget;
  logic [511:0] outData;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;

  evt_record_parser u_evt_record_parser (
    .clk(clk), .rst(rst), .inData(inData), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outChannel(outChannel),
    .outTimestamp(outTimestamp), .outAddress(outAddress), .outTarget(outTarget),
    .outData(outData), .errPulse(errPulse), .eosPulse(eosPulse)
  );

  // {len[135:128], chan[127:104], ts[103:40], addr[39:32], seed[31:0]}
  localparam logic [135:0] VECS [6] = '{
    {8'd13, 24'h123456, 64'h0102030405060708, 8'h9A, 32'h00000000},
    {8'd17, 24'hABCDEF, 64'hFEDCBA9876543210, 8'h01, 32'hDEADBEEF},
    {8'd29, 24'h000001, 64'h8000000000000001, 8'hFF, 32'h11223344},
    {8'd77, 24'hFFFFFF, 64'hFFFFFFFFFFFFFFFF, 8'h5A, 32'hA5A5A5A5},
    {8'd21, 24'h800000, 64'h0000000100000000, 8'h00, 32'h0F0F0F0F},
    {8'd45, 24'h0F1E2D, 64'h1122334455667788, 8'h3C, 32'h76543210}
  };

  task automatic check(input bit ok, input string tag, input logic [511:0] act,
                       input logic [511:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [511:0] expData(input logic [7:0] len, input logic [31:0] seed);
    logic [511:0] d = '0;
    int words = (int'(len) - 13) / 4;
    for (int k = 0; k < 16; k++)
      if (k < words) d[32*k +: 32] = seed + 32'(k) * 32'h01020305;
    return d;
  endfunction

  // called at a negedge; returns at the negedge after the byte is taken
  task automatic sendByte(input logic [7:0] b);
    inValid = 1'b1;
    inData  = b;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic sendRecord(input logic [135:0] v);
    logic [511:0] d = expData(v[135:128], v[31:0]);
    int words = (int'(v[135:128]) - 13) / 4;
    sendByte(v[135:128]);
    for (int i = 0; i < 3; i++) sendByte(v[104 + 8*i +: 8]);
    for (int i = 0; i < 8; i++) sendByte(v[40 + 8*i +: 8]);
    sendByte(v[39:32]);
    for (int i = 0; i < 4*words; i++) sendByte(d[8*i +: 8]);
  endtask

  task automatic expectEvent(input logic [135:0] v, input string tag);
    logic [511:0] d = expData(v[135:128], v[31:0]);
    check(outValid === 1'b1, {tag, " R1 event valid"}, 512'(outValid), 512'd1);
    check(outChannel === v[127:104], {tag, " R2 channel"}, 512'(outChannel), 512'(v[127:104]));
    check(outTimestamp === v[103:40], {tag, " R2 timestamp"}, 512'(outTimestamp), 512'(v[103:40]));
    check(outAddress === v[39:32], {tag, " R3 address"}, 512'(outAddress), 512'(v[39:32]));
    check(outTarget === {v[127:104], v[39:32]}, {tag, " R3 target"}, 512'(outTarget),
          512'({v[127:104], v[39:32]}));
    check(outData === d, {tag, " R4 data"}, outData, d);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    check(outValid === 1'b0, {tag, " R1 consumed"}, 512'(outValid), 512'd0);
  endtask

  task automatic sendBad(input logic [7:0] len, input logic [7:0] fill, input string tag);
    bit stray = 0;
    sendByte(len);
    check(errPulse === 1'b1 && outValid === 1'b0, {tag, " R5 error pulse"},
          512'(errPulse), 512'd1);
    for (int i = 1; i < int'(len); i++) begin
      sendByte(fill);
      if (outValid || eosPulse || errPulse) stray = 1;
    end
    check(!stray, {tag, " R6 skipped bytes silent"}, 512'(stray), 512'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks + 1 - nFail, nChecks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check(inReady === 1'b1 && outValid === 1'b0 && errPulse === 1'b0 && eosPulse === 1'b0,
          "R9 reset state", 512'({inReady, outValid, errPulse, eosPulse}), 512'b1000);

    for (int n = 0; n < 6; n++) begin
      sendRecord(VECS[n]);
      expectEvent(VECS[n], (n == 3) ? "R10 full record" : "table");
    end
    // R4 zero-extension after the full record
    sendRecord(VECS[1]);
    expectEvent(VECS[1], "R4 short after full");

    // R5/R6 rejected lengths
    sendBad(8'd14, 8'hFF, "len14");
    sendRecord(VECS[4]);
    expectEvent(VECS[4], "R6 after len14");
    sendBad(8'd5, 8'h00, "len5");
    sendBad(8'd81, 8'h00, "len81");
    sendBad(8'd12, 8'h00, "len12");
    sendBad(8'd1, 8'h00, "len1");
    sendRecord(VECS[0]);
    expectEvent(VECS[0], "R6 after several bad");

    // R7 end of stream
    sendByte(8'd0);
    check(eosPulse === 1'b1 && outValid === 1'b0, "R7 eos pulse", 512'(eosPulse), 512'd1);
    @(negedge clk);
    check(eosPulse === 1'b0, "R7 eos one cycle", 512'(eosPulse), 512'd0);
    sendRecord(VECS[2]);
    expectEvent(VECS[2], "R7 parse after eos");

    // R8 backpressure
    sendRecord(VECS[1]);
    inValid = 1'b1;
    inData  = 8'd0;
    begin
      bit bad = 0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (inReady || !outValid || eosPulse || outTarget !== {VECS[1][127:104], VECS[1][39:32]})
          bad = 1;
      end
      check(!bad, "R8 stall holds", 512'(bad), 512'd0);
    end
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    check(outValid === 1'b0 && inReady === 1'b1, "R8 released", 512'(outValid), 512'd0);
    @(negedge clk);
    inValid = 1'b0;
    check(eosPulse === 1'b1, "R8 held byte taken", 512'(eosPulse), 512'd1);

    // R9 reset mid-record
    sendByte(8'd29);
    sendByte(8'h11);
    sendByte(8'h22);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(inReady === 1'b1 && outValid === 1'b0 && outData === '0 && outTarget === '0,
          "R9 mid-record reset", 512'(outTarget), 512'd0);
    sendRecord(VECS[1]);
    expectEvent(VECS[1], "R9 parse after reset");

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule